// File: doc/BRIEF.md
# Region Miss Order Log

This block keeps an ordered log of trigger accesses for a spatial-region prefetcher. Each accepted trigger writes one entry: the spatial region number, an index into a separate pattern table, and a gap count. The gap count is the number of non-trigger accesses seen since the previous trigger. The log is a ring of fixed depth. Once it is full, each new entry replaces the oldest one.

A lookup port takes a region number and walks the log from the newest entry back toward the oldest. It reports the slot of the first entry that matches, or a miss. A read port returns the entry held in any slot, whether that slot is live, and whether it is the newest. A consumer can step a position forward from a lookup result to the newest entry and so rebuild the recorded sequence.

An optional mode drops a push that repeats an existing entry on all three fields. The duplicate check and the lookup each examine one entry per cycle. While either one runs, the block shows busy and ignores new requests.

Top module: `region_miss_log`

## Requirements
- R1: After synchronous active-low reset, every slot reads as not live, rd_last_o is low, busy_o is low, search_done_o is low and the gap counter is zero.
- R2: Each cycle with access_i high adds one to the gap counter. The counter saturates at 2^DELTA_W-1 instead of wrapping.
- R3: A push accepted in a cycle stores the region, the pattern index and the gap counter value of that cycle. In the same cycle the counter restarts: it reads 1 if access_i is also high in that cycle, otherwise 0. This restart happens even when the push is later dropped as a duplicate.
- R4: Entries are written to slots 0, 1, 2 and so on from reset, wrapping modulo DEPTH. When all DEPTH slots are live, a new entry overwrites the oldest one.
- R5: When dedup_en_i is high in the accepting cycle, a push whose three fields all equal those of a live entry is not written.
- R6: With dedup_en_i high and n live entries (n > 0), busy_o is high for j+1 cycles after acceptance if the entry of age j (newest is age 0) is the first match, or for n cycles if no entry matches. A push that is written becomes readable once busy_o falls. A push with dedup_en_i low, or made to an empty log, is written at the accepting edge and raises no busy.
- R7: A search returns search_hit_o=1 and search_pos_o equal to the slot of the newest live entry whose region equals search_region_i.
- R8: A search with no live matching entry returns search_hit_o=0 and search_pos_o=0.
- R9: Let E0 be the accepting edge. search_done_o is high for the cycle after edge E0+L, where L=0 for an empty log, L=j+1 for a hit at age j, and L=n for a miss over n live entries. search_hit_o and search_pos_o hold until the next search completes.
- R10: The read port returns the fields of slot rd_pos_i in the same cycle. rd_valid_o is high for a live slot. rd_last_o is high only for the newest entry's slot.
- R11: Push and search are accepted only while busy_o is low. A push takes precedence over a search made in the same cycle. A search made in the same cycle as a push, or while busy_o is high, is dropped and never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| access_i | input | 1 | A non-trigger access occurred this cycle |
| dedup_en_i | input | 1 | Drop a push that duplicates a live entry |
| push_valid_i | input | 1 | Trigger push request |
| push_region_i | input | REGION_W | Region number of the trigger |
| push_pidx_i | input | PIDX_W | Pattern-table index of the trigger |
| search_valid_i | input | 1 | Lookup request |
| search_region_i | input | REGION_W | Region number to look up |
| busy_o | output | 1 | A duplicate check or a lookup is in progress |
| search_done_o | output | 1 | One-cycle pulse when a lookup result is ready |
| search_hit_o | output | 1 | The last lookup found a match |
| search_pos_o | output | $clog2(DEPTH) | Slot of the last lookup's match |
| rd_pos_i | input | $clog2(DEPTH) | Slot to read |
| rd_valid_o | output | 1 | The slot holds a live entry |
| rd_last_o | output | 1 | The slot holds the newest entry |
| rd_region_o | output | REGION_W | Region field of the slot |
| rd_pidx_o | output | PIDX_W | Pattern-index field of the slot |
| rd_delta_o | output | DELTA_W | Gap field of the slot |

## Verification
A lookup result is due L edges after the accepting edge: L=0 for an empty log, j+1 for a hit at age j, and n for a miss over n entries. The bench releases the request, counts edges until search_done_o appears and compares that count with L. A dedup push is checked the same way, by counting busy cycles against j+1 or n. After each operation the bench reads every slot through the combinational read port, away from the clock edge, and compares it with a model ring. The gap counter is observed through the delta that the next push records.

// File: rtl/rml_pkg.sv
// Package: shared types for the region miss order log.
// Assumes nothing beyond a single clock domain.
package rml_pkg;
    // Controller state: idle, duplicate scan in progress, lookup in progress.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DEDUP  = 2'd1,
        ST_SEARCH = 2'd2
    } scan_state_e;
endpackage

// File: rtl/rml_delta_cnt.sv
// Module: saturating counter of non-trigger accesses between triggers.
// Assumes clr_i marks the cycle in which a push is accepted.
module rml_delta_cnt #(
    parameter int DELTA_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc_i,
    input  logic               clr_i,
    output logic [DELTA_W-1:0] cnt_o
);
    localparam logic [DELTA_W-1:0] CNT_MAX = {DELTA_W{1'b1}};

    logic [DELTA_W-1:0] cnt_q;

    // Count accesses, restarting on an accepted push and holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= inc_i ? DELTA_W'(1) : '0;
        end else if (inc_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + DELTA_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    // R2
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && inc_i && !clr_i) |=> cnt_q == CNT_MAX);

    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !inc_i) |=> cnt_q == '0);
endmodule

// File: rtl/rml_store.sv
// Module: ring storage of log entries with write pointer and fill level.
// Provides one read port for the scan controller and one for the consumer.
// Assumes DEPTH is a power of two, so the pointer wraps by overflow.
module rml_store #(
    parameter int DEPTH    = 8,
    parameter int REGION_W = 8,
    parameter int PIDX_W   = 8,
    parameter int DELTA_W  = 4,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [REGION_W-1:0] wr_region_i,
    input  logic [PIDX_W-1:0]   wr_pidx_i,
    input  logic [DELTA_W-1:0]  wr_delta_i,
    input  logic [AW-1:0]       scan_pos_i,
    output logic [REGION_W-1:0] scan_region_o,
    output logic [PIDX_W-1:0]   scan_pidx_o,
    output logic [DELTA_W-1:0]  scan_delta_o,
    input  logic [AW-1:0]       rd_pos_i,
    output logic                rd_valid_o,
    output logic                rd_last_o,
    output logic [REGION_W-1:0] rd_region_o,
    output logic [PIDX_W-1:0]   rd_pidx_o,
    output logic [DELTA_W-1:0]  rd_delta_o,
    output logic [AW:0]         level_o,
    output logic [AW-1:0]       newest_o
);
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    logic [REGION_W-1:0] region_q [DEPTH];
    logic [PIDX_W-1:0]   pidx_q   [DEPTH];
    logic [DELTA_W-1:0]  delta_q  [DEPTH];
    logic [AW-1:0]       wr_ptr_q;
    logic [AW:0]         level_q;

    // One register set per slot, loaded when the write pointer selects it.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                region_q[s] <= '0;
                pidx_q[s]   <= '0;
                delta_q[s]  <= '0;
            end else if (wr_en_i && wr_ptr_q == AW'(s)) begin
                region_q[s] <= wr_region_i;
                pidx_q[s]   <= wr_pidx_i;
                delta_q[s]  <= wr_delta_i;
            end
        end
    end

    // Advance the write pointer and the fill level, the level stopping at full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            level_q  <= '0;
        end else if (wr_en_i) begin
            wr_ptr_q <= wr_ptr_q + AW'(1);
            if (level_q != FULL) level_q <= level_q + (AW+1)'(1);
        end
    end

    // Read ports and live/newest decode.
    always_comb begin
        scan_region_o = region_q[scan_pos_i];
        scan_pidx_o   = pidx_q[scan_pos_i];
        scan_delta_o  = delta_q[scan_pos_i];
        rd_region_o   = region_q[rd_pos_i];
        rd_pidx_o     = pidx_q[rd_pos_i];
        rd_delta_o    = delta_q[rd_pos_i];
        newest_o      = wr_ptr_q - AW'(1);
        rd_valid_o    = (level_q == FULL) || ({1'b0, rd_pos_i} < level_q);
        rd_last_o     = (level_q != '0) && (rd_pos_i == newest_o);
    end

    assign level_o = level_q;

    // R4
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= FULL);

    // R4
    level_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && level_q < FULL) |=> level_q == $past(level_q) + (AW+1)'(1));

    // R4
    full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q == FULL) |=> level_q == FULL);
endmodule

// File: rtl/rml_scan_ctrl.sv
// Module: accepts pushes and lookups, runs the one-entry-per-cycle
// duplicate scan and region lookup from newest to oldest, and issues writes.
// Assumes the store's level and newest slot change only through wr_en_o.
module rml_scan_ctrl
    import rml_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int REGION_W = 8,
    parameter int PIDX_W   = 8,
    parameter int DELTA_W  = 4,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dedup_en_i,
    input  logic                push_valid_i,
    input  logic [REGION_W-1:0] push_region_i,
    input  logic [PIDX_W-1:0]   push_pidx_i,
    input  logic                search_valid_i,
    input  logic [REGION_W-1:0] search_region_i,
    input  logic [DELTA_W-1:0]  delta_i,
    input  logic [AW:0]         level_i,
    input  logic [AW-1:0]       newest_i,
    input  logic [REGION_W-1:0] scan_region_i,
    input  logic [PIDX_W-1:0]   scan_pidx_i,
    input  logic [DELTA_W-1:0]  scan_delta_i,
    output logic [AW-1:0]       scan_pos_o,
    output logic                wr_en_o,
    output logic [REGION_W-1:0] wr_region_o,
    output logic [PIDX_W-1:0]   wr_pidx_o,
    output logic [DELTA_W-1:0]  wr_delta_o,
    output logic                clr_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                hit_o,
    output logic [AW-1:0]       pos_o
);
    scan_state_e         state_q;
    logic [AW-1:0]       age_q;
    logic [REGION_W-1:0] pend_region_q;
    logic [PIDX_W-1:0]   pend_pidx_q;
    logic [DELTA_W-1:0]  pend_delta_q;
    logic [REGION_W-1:0] key_q;
    logic                done_q;
    logic                hit_q;
    logic [AW-1:0]       pos_q;

    logic idle;
    logic push_acc;
    logic push_direct;
    logic last_age;
    logic dup_match;
    logic reg_match;

    // Decode acceptance, scan position and per-cycle comparisons.
    always_comb begin
        idle        = (state_q == ST_IDLE);
        push_acc    = idle && push_valid_i;
        push_direct = push_acc && !(dedup_en_i && level_i != '0);
        scan_pos_o  = newest_i - age_q;
        last_age    = ({1'b0, age_q} == level_i - (AW+1)'(1));
        dup_match   = (scan_region_i == pend_region_q) &&
                      (scan_pidx_i == pend_pidx_q) &&
                      (scan_delta_i == pend_delta_q);
        reg_match   = (scan_region_i == key_q);
    end

    // Select the write source: a direct push or the end of a clean dedup scan.
    always_comb begin
        wr_en_o     = 1'b0;
        wr_region_o = push_region_i;
        wr_pidx_o   = push_pidx_i;
        wr_delta_o  = delta_i;
        if (push_direct) begin
            wr_en_o = 1'b1;
        end else if (state_q == ST_DEDUP && !dup_match && last_age) begin
            wr_en_o     = 1'b1;
            wr_region_o = pend_region_q;
            wr_pidx_o   = pend_pidx_q;
            wr_delta_o  = pend_delta_q;
        end
    end

    // Sequence the scans and register lookup results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            age_q         <= '0;
            pend_region_q <= '0;
            pend_pidx_q   <= '0;
            pend_delta_q  <= '0;
            key_q         <= '0;
            done_q        <= 1'b0;
            hit_q         <= 1'b0;
            pos_q         <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    age_q <= '0;
                    if (push_valid_i) begin
                        pend_region_q <= push_region_i;
                        pend_pidx_q   <= push_pidx_i;
                        pend_delta_q  <= delta_i;
                        if (!push_direct) state_q <= ST_DEDUP;
                    end else if (search_valid_i) begin
                        key_q <= search_region_i;
                        if (level_i == '0) begin
                            done_q <= 1'b1;
                            hit_q  <= 1'b0;
                            pos_q  <= '0;
                        end else begin
                            state_q <= ST_SEARCH;
                        end
                    end
                end
                ST_DEDUP: begin
                    if (dup_match || last_age) state_q <= ST_IDLE;
                    else                       age_q   <= age_q + AW'(1);
                end
                ST_SEARCH: begin
                    if (reg_match) begin
                        done_q  <= 1'b1;
                        hit_q   <= 1'b1;
                        pos_q   <= scan_pos_o;
                        state_q <= ST_IDLE;
                    end else if (last_age) begin
                        done_q  <= 1'b1;
                        hit_q   <= 1'b0;
                        pos_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        age_q <= age_q + AW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign clr_o  = push_acc;
    assign busy_o = !idle;
    assign done_o = done_q;
    assign hit_o  = hit_q;
    assign pos_o  = pos_q;

    // R11
    search_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |=> $stable(level_i));

    // R6
    scan_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> level_i != '0);

    // R8
    miss_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !hit_q) |-> pos_q == '0);

    // R5
    dup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEDUP && dup_match) |-> !wr_en_o);
endmodule

// File: rtl/region_miss_log.sv
// Module: top of the region miss order log. Wires the gap counter, the
// ring storage and the scan controller together.
// Assumes DEPTH is a power of two and all inputs are synchronous to clk.
module region_miss_log #(
    parameter int DEPTH    = 8,
    parameter int REGION_W = 8,
    parameter int PIDX_W   = 8,
    parameter int DELTA_W  = 4,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                access_i,
    input  logic                dedup_en_i,
    input  logic                push_valid_i,
    input  logic [REGION_W-1:0] push_region_i,
    input  logic [PIDX_W-1:0]   push_pidx_i,
    input  logic                search_valid_i,
    input  logic [REGION_W-1:0] search_region_i,
    output logic                busy_o,
    output logic                search_done_o,
    output logic                search_hit_o,
    output logic [AW-1:0]       search_pos_o,
    input  logic [AW-1:0]       rd_pos_i,
    output logic                rd_valid_o,
    output logic                rd_last_o,
    output logic [REGION_W-1:0] rd_region_o,
    output logic [PIDX_W-1:0]   rd_pidx_o,
    output logic [DELTA_W-1:0]  rd_delta_o
);
    logic [DELTA_W-1:0]  cnt;
    logic                clr;
    logic                wr_en;
    logic [REGION_W-1:0] wr_region;
    logic [PIDX_W-1:0]   wr_pidx;
    logic [DELTA_W-1:0]  wr_delta;
    logic [AW-1:0]       scan_pos;
    logic [REGION_W-1:0] scan_region;
    logic [PIDX_W-1:0]   scan_pidx;
    logic [DELTA_W-1:0]  scan_delta;
    logic [AW:0]         level;
    logic [AW-1:0]       newest;

    rml_delta_cnt #(.DELTA_W(DELTA_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (access_i),
        .clr_i (clr),
        .cnt_o (cnt)
    );

    rml_store #(
        .DEPTH(DEPTH), .REGION_W(REGION_W), .PIDX_W(PIDX_W), .DELTA_W(DELTA_W)
    ) i_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_region_i   (wr_region),
        .wr_pidx_i     (wr_pidx),
        .wr_delta_i    (wr_delta),
        .scan_pos_i    (scan_pos),
        .scan_region_o (scan_region),
        .scan_pidx_o   (scan_pidx),
        .scan_delta_o  (scan_delta),
        .rd_pos_i      (rd_pos_i),
        .rd_valid_o    (rd_valid_o),
        .rd_last_o     (rd_last_o),
        .rd_region_o   (rd_region_o),
        .rd_pidx_o     (rd_pidx_o),
        .rd_delta_o    (rd_delta_o),
        .level_o       (level),
        .newest_o      (newest)
    );

    rml_scan_ctrl #(
        .DEPTH(DEPTH), .REGION_W(REGION_W), .PIDX_W(PIDX_W), .DELTA_W(DELTA_W)
    ) i_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .dedup_en_i      (dedup_en_i),
        .push_valid_i    (push_valid_i),
        .push_region_i   (push_region_i),
        .push_pidx_i     (push_pidx_i),
        .search_valid_i  (search_valid_i),
        .search_region_i (search_region_i),
        .delta_i         (cnt),
        .level_i         (level),
        .newest_i        (newest),
        .scan_region_i   (scan_region),
        .scan_pidx_i     (scan_pidx),
        .scan_delta_i    (scan_delta),
        .scan_pos_o      (scan_pos),
        .wr_en_o         (wr_en),
        .wr_region_o     (wr_region),
        .wr_pidx_o       (wr_pidx),
        .wr_delta_o      (wr_delta),
        .clr_o           (clr),
        .busy_o          (busy_o),
        .done_o          (search_done_o),
        .hit_o           (search_hit_o),
        .pos_o           (search_pos_o)
    );

    // R11
    busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && push_valid_i && !wr_en) |=> $stable(level));
endmodule

// File: tb/test_region_miss_log.sv
// Bench: small configuration (4 slots, 4-bit region/index, 3-bit gap),
// compared against a model ring kept in plain integers.
module test_region_miss_log;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int RW = 4;
    localparam int PW = 4;
    localparam int DW = 3;
    localparam int AW = 2;
    localparam int DMAX = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic access_i = 1'b0;
    logic dedup_en_i = 1'b0;
    logic push_valid_i = 1'b0;
    logic [RW-1:0] push_region_i = '0;
    logic [PW-1:0] push_pidx_i = '0;
    logic search_valid_i = 1'b0;
    logic [RW-1:0] search_region_i = '0;
    logic busy_o, search_done_o, search_hit_o;
    logic [AW-1:0] search_pos_o;
    logic [AW-1:0] rd_pos_i = '0;
    logic rd_valid_o, rd_last_o;
    logic [RW-1:0] rd_region_o;
    logic [PW-1:0] rd_pidx_o;
    logic [DW-1:0] rd_delta_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int m_reg [DEPTH];
    int m_pid [DEPTH];
    int m_del [DEPTH];
    int m_wr = 0;
    int m_lvl = 0;
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    region_miss_log #(.DEPTH(DEPTH), .REGION_W(RW), .PIDX_W(PW), .DELTA_W(DW)) i_region_miss_log (
        .clk(clk), .rst_n(rst_n), .access_i(access_i), .dedup_en_i(dedup_en_i),
        .push_valid_i(push_valid_i), .push_region_i(push_region_i), .push_pidx_i(push_pidx_i),
        .search_valid_i(search_valid_i), .search_region_i(search_region_i),
        .busy_o(busy_o), .search_done_o(search_done_o), .search_hit_o(search_hit_o),
        .search_pos_o(search_pos_o), .rd_pos_i(rd_pos_i), .rd_valid_o(rd_valid_o),
        .rd_last_o(rd_last_o), .rd_region_o(rd_region_o), .rd_pidx_o(rd_pidx_o),
        .rd_delta_o(rd_delta_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Age j (0 = newest) to slot index in the model.
    function automatic int slot_of_age(int j);
        return ((m_wr - 1 - j) % DEPTH + DEPTH) % DEPTH;
    endfunction

    // R10 R4 R3: read every slot and compare with the model.
    task automatic check_store(input string tag);
        for (int p = 0; p < DEPTH; p++) begin
            bit live;
            rd_pos_i = AW'(p);
            #1;
            live = (m_lvl == DEPTH) || (p < m_lvl);
            check({tag, " R10 valid"}, int'(rd_valid_o), int'(live));
            check({tag, " R10 last"}, int'(rd_last_o),
                  int'(m_lvl > 0 && p == slot_of_age(0)));
            if (live) begin
                check({tag, " R4 region"}, int'(rd_region_o), m_reg[p]);
                check({tag, " R4 pidx"}, int'(rd_pidx_o), m_pid[p]);
                check({tag, " R3 delta"}, int'(rd_delta_o), m_del[p]);
            end
        end
    endtask

    // R2: drive n access pulses; model saturates.
    task automatic do_access(input int n);
        for (int i = 0; i < n; i++) begin
            access_i = 1'b1;
            tick();
            if (m_cnt < DMAX) m_cnt++;
        end
        access_i = 1'b0;
    endtask

    // Push with model of dedup and busy length; optional same-cycle access
    // and a search poke during the first busy cycle.
    task automatic do_push(input int r, input int p, input bit dd,
                           input bit acc_same, input bit poke);
        int match_j;
        int exp_busy;
        int got_busy;
        int d;
        d = m_cnt;
        match_j = -1;
        if (dd) begin
            for (int j = 0; j < m_lvl; j++) begin
                int s;
                s = slot_of_age(j);
                if (match_j < 0 && m_reg[s] == r && m_pid[s] == p && m_del[s] == d) match_j = j;
            end
        end
        exp_busy = (dd && m_lvl > 0) ? ((match_j >= 0) ? match_j + 1 : m_lvl) : 0;
        check("R11 idle before push", int'(busy_o), 0);
        push_valid_i = 1'b1;
        push_region_i = RW'(r);
        push_pidx_i = PW'(p);
        dedup_en_i = dd;
        access_i = acc_same;
        tick();
        push_valid_i = 1'b0;
        access_i = 1'b0;
        m_cnt = acc_same ? 1 : 0;
        got_busy = 0;
        while (busy_o && got_busy < 20) begin
            search_valid_i = poke && got_busy == 0;
            search_region_i = RW'(r);
            tick();
            search_valid_i = 1'b0;
            check("R11 no done while busy", int'(search_done_o), 0);
            got_busy++;
        end
        check("R6 busy cycles", got_busy, exp_busy);
        if (match_j < 0) begin
            m_reg[m_wr] = r;
            m_pid[m_wr] = p;
            m_del[m_wr] = d;
            m_wr = (m_wr + 1) % DEPTH;
            if (m_lvl < DEPTH) m_lvl++;
        end
        if (poke) begin
            tick();
            check("R11 poked search dropped", int'(search_done_o), 0);
        end
        check_store(dd ? "R5" : "R4");
    endtask

    // R7 R8 R9: search and measure latency.
    task automatic do_search(input int r);
        int exp_j;
        int exp_l;
        int got_l;
        exp_j = -1;
        for (int j = 0; j < m_lvl; j++)
            if (exp_j < 0 && m_reg[slot_of_age(j)] == r) exp_j = j;
        exp_l = (m_lvl == 0) ? 0 : ((exp_j >= 0) ? exp_j + 1 : m_lvl);
        search_valid_i = 1'b1;
        search_region_i = RW'(r);
        tick();
        search_valid_i = 1'b0;
        got_l = 0;
        while (!search_done_o && got_l < 20) begin
            tick();
            got_l++;
        end
        check("R9 latency", got_l, exp_l);
        if (exp_j >= 0) begin
            check("R7 hit", int'(search_hit_o), 1);
            check("R7 pos", int'(search_pos_o), slot_of_age(exp_j));
        end else begin
            check("R8 miss", int'(search_hit_o), 0);
            check("R8 pos", int'(search_pos_o), 0);
        end
        tick();
        check("R9 done pulse", int'(search_done_o), 0);
        check("R9 hit held", int'(search_hit_o), int'(exp_j >= 0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_reg[i] = 0; m_pid[i] = 0; m_del[i] = 0;
        end
        @(negedge clk);
        tick();
        tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 busy", int'(busy_o), 0);
        check("R1 done", int'(search_done_o), 0);
        check_store("R1");
        do_push(9, 9, 1'b0, 1'b0, 1'b0);
        check("R1 delta zero after reset", m_del[0], 0);
        // restart from an empty log for the empty-search case
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        m_wr = 0; m_lvl = 0; m_cnt = 0;
        check_store("R1");
        do_search(3);
        // R4 fill past depth with varied gaps and regions
        for (int i = 0; i < 6; i++) begin
            do_access(i);
            do_push(i % 3, i + 1, i % 2, 1'b0, 1'b0);
        end
        // R7 R8 R9 sweep over every region value
        for (int r = 0; r < (1 << RW); r++) do_search(r);
        // R5 R6 duplicates of each live entry, oldest to newest
        for (int j = DEPTH - 1; j >= 0; j--) begin
            int s;
            s = slot_of_age(j);
            do_access(m_del[s]);
            do_push(m_reg[s], m_pid[s], 1'b1, 1'b0, 1'b0);
        end
        // R2 saturation, recorded as the next delta
        do_access(DMAX + 3);
        do_push(5, 5, 1'b1, 1'b0, 1'b0);
        // R3 access in the push cycle carries into the next gap
        do_push(6, 6, 1'b0, 1'b1, 1'b0);
        do_push(7, 7, 1'b0, 1'b0, 1'b0);
        check("R3 carry delta", m_del[slot_of_age(0)], 1);
        // R11 search while busy is dropped
        do_push(8, 8, 1'b1, 1'b0, 1'b1);
        // R11 push and search in one cycle: push wins, search dropped
        push_valid_i = 1'b1; push_region_i = 4'd2; push_pidx_i = 4'd3; dedup_en_i = 1'b0;
        search_valid_i = 1'b1; search_region_i = 4'd2;
        tick();
        push_valid_i = 1'b0; search_valid_i = 1'b0;
        m_reg[m_wr] = 2; m_pid[m_wr] = 3; m_del[m_wr] = m_cnt;
        m_wr = (m_wr + 1) % DEPTH; m_cnt = 0;
        for (int k = 0; k < 3; k++) begin
            check("R11 simultaneous search dropped", int'(search_done_o), 0);
            tick();
        end
        check_store("R11");
        do_search(2);
        finish_run();
    end
endmodule